// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host access to a bank of 256 byte-wide configuration registers through only two I/O addresses. The host first writes a register number to the lower address of the pair, then reads or writes the selected register through the upper address. The selected register number is held in register 0 itself, so the bank has no separate pointer register. The lower address reads back that number.

Many registers are read-only. A data write to one of them is dropped without any error. A fixed set of registers comes out of reset with non-zero values that the consuming peripherals decode, such as an identification byte and base-address bytes. All other registers, including the register number, reset to zero. The port answers only while an external enable input is high and the bus address falls on the configured pair. At all other times it returns 0xFF and ignores writes.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, register 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE and 0xE8 reads 0xBE. Every other register, including the selected number, reads 0x00.
- R2: A write to the pair address with bit 0 clear stores the data byte as the selected register number. A read at that address returns the selected number.
- R3: A data write (pair address with bit 0 set) to a selected number in 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC updates that register. A later data read returns the new value.
- R4: A data write to any other selected number leaves the register unchanged: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R5: A data read while the selected number is 0 returns 0x00, not the stored number.
- R6: While the enable input is low, reads return 0xFF and writes at either address change nothing.
- R7: Only the two addresses BASE and BASE+1 (default 0x3F0, 0x3F1) are decoded. Other addresses read 0xFF and their writes change nothing.
- R8: When the read strobe is low, the read data bus is 0xFF. Read data is combinational and valid during the read strobe. A write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable from host configuration |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not answering |

## Verification
Every register number is swept three times. The first sweep reads reset contents, which separates the six preset registers from the zero ones. The second sweep writes a value derived from the number, which tells writable registers from protected ones. The third sweep writes the complement, which catches stuck bits. Number 0 is probed separately to tell the index-readback path from the zero-return data path. Writes with enable low and writes to a neighbouring address must leave both the selected number and a writable register unchanged.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int DW = 8,
  parameter int IDX_W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h03F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata
);
  localparam int NREG = 1 << IDX_W;
  localparam logic [DW-1:0] IDLE = '1;

  function automatic logic wr_ok_f(int i);
    return (i >= 'hE0 && i <= 'hE3) || (i >= 'hE6 && i <= 'hE8) ||
           (i >= 'hEE && i <= 'hF2) || i == 'hF4 || i == 'hF6 ||
           i == 'hF8 || i == 'hFC;
  endfunction

  function automatic logic [DW-1:0] rst_val_f(int i);
    case (i)
      'hE0: return DW'('h3C);
      'hE2: return DW'('h03);
      'hE3: return DW'('hFC);
      'hE6: return DW'('hDE);
      'hE7: return DW'('hFE);
      'hE8: return DW'('hBE);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0]    regs [NREG];
  logic [IDX_W-1:0] idx;
  logic             hit, acc, wr_ok;

  assign idx   = regs[0][IDX_W-1:0];
  assign hit   = io_addr[AW-1:1] == BASE[AW-1:1];
  assign acc   = port_en && hit;
  assign wr_ok = wr_ok_f(int'(idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val_f(i);
    end else if (acc && io_wr) begin
      if (!io_addr[0]) regs[0] <= io_wdata;
      else if (wr_ok) regs[idx] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = IDLE;
    if (acc && io_rd) begin
      if (!io_addr[0]) io_rdata = DW'(idx);
      else if (idx == '0) io_rdata = '0;
      else io_rdata = regs[idx];
    end
  end

  logic             prot_q;
  logic [IDX_W-1:0] prot_idx_q;
  logic [DW-1:0]    prot_val_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      prot_idx_q <= '0;
      prot_val_q <= '0;
    end else begin
      prot_q <= acc && io_wr && io_addr[0] && !wr_ok;
      prot_idx_q <= idx;
      prot_val_q <= regs[idx];
    end
  end

  p_idx_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && io_wr && !io_addr[0]) |=> regs[0] == $past(io_wdata));
  p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && io_wr && io_addr[0] && wr_ok) |=> regs[$past(idx)] == $past(io_wdata));
  p_prot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_q |-> regs[prot_idx_q] == prot_val_q);
  p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && io_rd && io_addr[0] && idx == '0) |-> io_rdata == '0);
  p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> io_rdata == IDLE);
  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && io_wr) |=> $stable(regs[0]));
  p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && io_wr) |=> $stable(regs[0]));
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == IDLE);
endmodule

// File: tb/cfg_index_port_tb_top.sv
module cfg_index_port_tb_top;
  logic clk = 0, rst_n = 0, port_en = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0] io_wdata = 8'h0, io_rdata;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  cfg_index_port dut_i (.clk(clk), .rst_n(rst_n), .port_en(port_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata));

  function automatic logic can_wr(int i);
    return (i >= 'hE0 && i <= 'hE3) || (i >= 'hE6 && i <= 'hE8) ||
           (i >= 'hEE && i <= 'hF2) || i == 'hF4 || i == 'hF6 || i == 'hF8 || i == 'hFC;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    io_rd = 0;
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model['hE0] = 8'h3C; model['hE2] = 8'h03; model['hE3] = 8'hFC;
    model['hE6] = 8'hDE; model['hE7] = 8'hFE; model['hE8] = 8'hBE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R8 idle bus", io_rdata, 8'hFF);
    port_en = 1;
    rd(16'h03F0, v); chk("R1 index reset", v, 8'h00);
    rd(16'h03F1, v); chk("R5 read at index 0", v, 8'h00);
    for (int i = 0; i < 256; i++) begin
      wr(16'h03F0, 8'(i));
      rd(16'h03F0, v); chk("R2 index readback", v, 8'(i));
      rd(16'h03F1, v); chk("R1 reset value", v, (i == 0) ? 8'h00 : model[i]);
    end
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 1; i < 256; i++) begin
        logic [7:0] d;
        d = (pass == 0) ? (8'(i) ^ 8'h5A) : ~(8'(i) ^ 8'h5A);
        wr(16'h03F0, 8'(i));
        wr(16'h03F1, d);
        if (can_wr(i)) model[i] = d;
        rd(16'h03F1, v);
        chk(can_wr(i) ? "R3 writable" : "R4 protected", v, model[i]);
      end
    end
    wr(16'h03F0, 8'h00);
    wr(16'h03F1, 8'h77);
    rd(16'h03F0, v); chk("R4 data write at index 0", v, 8'h00);
    rd(16'h03F1, v); chk("R5 zero at index 0", v, 8'h00);
    wr(16'h03F0, 8'hEF);
    port_en = 0;
    rd(16'h03F0, v); chk("R6 disabled read", v, 8'hFF);
    wr(16'h03F0, 8'hF0);
    wr(16'h03F1, 8'h11);
    port_en = 1;
    rd(16'h03F0, v); chk("R6 index held", v, 8'hEF);
    rd(16'h03F1, v); chk("R6 data held", v, model['hEF]);
    rd(16'h03F2, v); chk("R7 outside read", v, 8'hFF);
    rd(16'h03EF, v); chk("R7 below read", v, 8'hFF);
    wr(16'h03F2, 8'h22);
    wr(16'h13F1, 8'h33);
    rd(16'h03F0, v); chk("R7 index held", v, 8'hEF);
    rd(16'h03F1, v); chk("R7 data held", v, model['hEF]);
    @(negedge clk); io_addr = 16'h03F1; #1 chk("R8 no strobe", io_rdata, 8'hFF);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule